// File: doc/BRIEF.md
# Host controller run/stop/reset sequencer

This block is the control core that sits behind a bus host controller's command and status bits. Software writes a run request and a self-clearing controller-reset request through a simple write port, and reads back the run bit, the reset-in-progress bit and a halted flag. On the other side, the block talks to a schedule-execution engine. It grants the engine permission to run. It learns from the engine whether a bus transaction is in flight and when that transaction completes. It is told when a memory read came back with a bad status.

The sequencer has four states. HALTED is the state after power-up. RUNNING means the engine may issue work. STOPPING means run is cleared but a transaction is still finishing. RESETTING is a fixed-length internal reset. The named transitions are as follows:
- start: HALTED to RUNNING, on a run=1 write.
- graceful_stop: RUNNING to STOPPING, on a run=0 write or a failed read while a transaction is in flight.
- quick_stop: RUNNING to HALTED, on the same requests with no transaction left.
- drain_done: STOPPING to HALTED, on transaction done.
- soft_reset: from any of the three other states to RESETTING, on a reset=1 write.
- reset_done: RESETTING to HALTED, after RST_CYCLES cycles.

While it is in RESETTING, the block holds reset on the internal pipelines and on the port state. On entry to RESETTING it aborts the current transaction and hands port ownership back to the companion controller. It drives no reset onto the downstream bus, and it does not touch configuration or capability registers.

Top module: `hc_runctl`

## Requirements
- R1: After rst_n is deasserted, the outputs read as follows: rd_run=0, rd_halted=1, rd_hcreset=0, sched_enable=0, pipe_rst=0, port_rst=0, proto_err=0, xact_abort=0, owner_release=0.
- R2: A write with wr_run=1 and wr_hcreset=0 while halted takes effect on the next clock. From then on rd_run=1, rd_halted=0 and sched_enable=1, and sched_enable is 1 only in the running state.
- R3: rd_run=1 and rd_halted=1 never appear together.
- R4: A write with wr_run=0 and wr_hcreset=0 while running works as follows. If xact_busy=1 and xact_done=0 in that cycle, the block reads rd_run=0, rd_halted=0 until the clock after a cycle with xact_done=1, and then reads rd_halted=1. Otherwise it reads rd_halted=1 on the next clock.
- R5: rd_fail=1 while running stops the controller by the same path as a run=0 write.
- R6: A write with wr_hcreset=1 sets rd_hcreset=1, pipe_rst=1 and port_rst=1 for exactly RST_CYCLES (default 16) cycles, with rd_run=0 and rd_halted=0. After that, rd_hcreset=0, rd_halted=1 and rd_run=0.
- R7: In the first cycle of the reset, and only then, xact_abort and owner_release are 1.
- R8: Writes during the reset have no effect, including wr_hcreset=0 and wr_run=1. The reset still lasts its full length and ends halted.
- R9: proto_err pulses for one cycle after a write with wr_run=1 or wr_hcreset=1 while rd_halted=0 and rd_hcreset=0. In that case a reset request still starts the reset, and a run request made while stopping is ignored, so the block stays stopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Command write strobe |
| wr_run | input | 1 | Run bit value written |
| wr_hcreset | input | 1 | Controller-reset bit value written |
| xact_busy | input | 1 | Engine has a bus transaction in flight |
| xact_done | input | 1 | Engine finishes its transaction this cycle |
| rd_fail | input | 1 | A memory read returned a non-success status |
| rd_run | output | 1 | Run bit read value |
| rd_hcreset | output | 1 | Controller reset in progress |
| rd_halted | output | 1 | Halted status |
| sched_enable | output | 1 | Engine may issue transactions |
| xact_abort | output | 1 | One-cycle abort of the current transaction |
| pipe_rst | output | 1 | Reset to pipelines, timers and counters |
| port_rst | output | 1 | Reset to port registers and port state machines |
| owner_release | output | 1 | One-cycle return of port ownership to the companion |
| proto_err | output | 1 | One-cycle flag for a write made in a forbidden state |

## Verification
The bench targets a stop request that coincides with the last cycle of a transaction. A sequencer that sampled only xact_busy there would park in STOPPING forever and never raise halted. It also attempts to cancel the reset with a zero write and to restart with run=1 mid-reset. A block that obeyed either write would end the reset early, or come out of it running instead of halted. Failed reads while running, and reset or run requests while stopping, are checked for the right stop path and a single proto_err pulse. A design that let a run request revive a draining controller would show run=1 before halted is ever reached.

// File: rtl/hc_runctl_pkg.sv
package hc_runctl_pkg;

    typedef enum logic [1:0] {
        ST_HALTED,
        ST_RUN,
        ST_STOPPING,
        ST_RESET
    } hc_state_e;

endpackage

// File: rtl/hc_rst_timer.sv
module hc_rst_timer #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic done
);
    localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    // Loaded on entry, counts down while the reset is active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(RST_CYCLES - 1);
        end else if (active && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = active && (cnt_q == '0);

endmodule

// File: rtl/hc_runctl_fsm.sv
module hc_runctl_fsm
    import hc_runctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_run,
    input  logic      wr_hcreset,
    input  logic      xact_busy,
    input  logic      xact_done,
    input  logic      rd_fail,
    input  logic      rst_done,
    output hc_state_e state,
    output logic      rst_start,
    output logic      abort_pulse,
    output logic      perr_pulse
);
    hc_state_e state_q;
    hc_state_e state_d;
    logic      rst_req;
    logic      stop_req;
    hc_state_e stop_dest;
    logic      perr_d;

    assign rst_req   = wr_en && wr_hcreset;
    assign stop_req  = rd_fail || (wr_en && !wr_run);
    assign stop_dest = (xact_busy && !xact_done) ? ST_STOPPING : ST_HALTED;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (rst_req) begin
                    state_d = ST_RESET;          // soft_reset
                end else if (wr_en && wr_run) begin
                    state_d = ST_RUN;            // start
                end
            end
            ST_RUN: begin
                if (rst_req) begin
                    state_d = ST_RESET;          // soft_reset
                end else if (stop_req) begin
                    state_d = stop_dest;         // graceful_stop / quick_stop
                end
            end
            ST_STOPPING: begin
                if (rst_req) begin
                    state_d = ST_RESET;          // soft_reset
                end else if (xact_done) begin
                    state_d = ST_HALTED;         // drain_done
                end
            end
            ST_RESET: begin
                if (rst_done) begin
                    state_d = ST_HALTED;         // reset_done
                end
            end
            default: state_d = ST_HALTED;
        endcase
    end

    assign rst_start = (state_d == ST_RESET) && (state_q != ST_RESET);
    assign perr_d    = wr_en && (wr_run || wr_hcreset)
                       && (state_q == ST_RUN || state_q == ST_STOPPING);

    // Output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
            perr_pulse  <= 1'b0;
        end else begin
            abort_pulse <= rst_start;
            perr_pulse  <= perr_d;
        end
    end

    assign state = state_q;

    // R8
    reset_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET) && !rst_done |=> (state_q == ST_RESET));

    // R4
    drain_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPING) && !xact_done && !rst_req |=> (state_q == ST_STOPPING));

endmodule

// File: rtl/hc_runctl.sv
module hc_runctl
    import hc_runctl_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_run,
    input  logic wr_hcreset,
    input  logic xact_busy,
    input  logic xact_done,
    input  logic rd_fail,
    output logic rd_run,
    output logic rd_hcreset,
    output logic rd_halted,
    output logic sched_enable,
    output logic xact_abort,
    output logic pipe_rst,
    output logic port_rst,
    output logic owner_release,
    output logic proto_err
);
    localparam int LW = $clog2(RST_CYCLES + 1) + 1;

    hc_state_e state;
    logic      rst_start;
    logic      rst_done;
    logic      abort_pulse;
    logic      perr_pulse;

    hc_runctl_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_run     (wr_run),
        .wr_hcreset (wr_hcreset),
        .xact_busy  (xact_busy),
        .xact_done  (xact_done),
        .rd_fail    (rd_fail),
        .rst_done   (rst_done),
        .state      (state),
        .rst_start  (rst_start),
        .abort_pulse(abort_pulse),
        .perr_pulse (perr_pulse)
    );

    hc_rst_timer #(.RST_CYCLES(RST_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .active(state == ST_RESET),
        .done  (rst_done)
    );

    // State decode to the register view and the reset fan-out
    always_comb begin
        rd_run        = (state == ST_RUN);
        rd_halted     = (state == ST_HALTED);
        rd_hcreset    = (state == ST_RESET);
        sched_enable  = (state == ST_RUN);
        pipe_rst      = (state == ST_RESET);
        port_rst      = (state == ST_RESET);
        xact_abort    = abort_pulse;
        owner_release = abort_pulse;
        proto_err     = perr_pulse;
    end

    // Length of the current reset, counted for the checks below
    logic [LW-1:0] rst_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_len_q <= '0;
        end else if (rd_hcreset) begin
            rst_len_q <= rst_len_q + 1'b1;
        end else begin
            rst_len_q <= '0;
        end
    end

    // R3
    no_run_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_run && rd_halted));

    // R2
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_halted && wr_en && wr_run && !wr_hcreset |=> rd_run && !rd_halted && sched_enable);

    // R4
    stop_no_early_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_run && !rd_halted && !rd_hcreset && !xact_done |=> !rd_halted);

    // R5
    fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_run && rd_fail && !(wr_en && wr_hcreset) |=> !rd_run);

    // R6
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_hcreset) |-> (rst_len_q == LW'(RST_CYCLES)) && rd_halted && !rd_run);

    // R6
    rst_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hcreset |-> pipe_rst && port_rst && !rd_run && !rd_halted);

    // R7
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_hcreset) |-> xact_abort && owner_release);

    // R9
    perr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_hcreset && !rd_halted && !rd_hcreset |=> proto_err && rd_hcreset);

endmodule

// File: tb/test_hc_runctl.sv
module test_hc_runctl;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC       = 16;
    localparam int M_HALT = 0, M_RUN = 1, M_STOP = 2, M_RST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_run = 1'b0, wr_hcreset = 1'b0;
    logic xact_busy = 1'b0, xact_done = 1'b0, rd_fail = 1'b0;
    logic rd_run, rd_hcreset, rd_halted, sched_enable, xact_abort;
    logic pipe_rst, port_rst, owner_release, proto_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int exp_st = M_HALT;
    int exp_cnt = 0;
    bit exp_perr = 1'b0;
    bit exp_abort = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_runctl #(.RST_CYCLES(RSTC)) i_hc_runctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_run(wr_run),
        .wr_hcreset(wr_hcreset), .xact_busy(xact_busy), .xact_done(xact_done),
        .rd_fail(rd_fail), .rd_run(rd_run), .rd_hcreset(rd_hcreset),
        .rd_halted(rd_halted), .sched_enable(sched_enable), .xact_abort(xact_abort),
        .pipe_rst(pipe_rst), .port_rst(port_rst), .owner_release(owner_release),
        .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Next expected state from the requirements
    task automatic model_update();
        int nst;
        bit stop_to_stop;
        nst = exp_st;
        stop_to_stop = xact_busy && !xact_done;
        exp_perr  = wr_en && (wr_run || wr_hcreset) && (exp_st == M_RUN || exp_st == M_STOP);
        exp_abort = 1'b0;
        case (exp_st)
            M_HALT: if (wr_en && wr_hcreset) nst = M_RST;
                    else if (wr_en && wr_run) nst = M_RUN;
            M_RUN:  if (wr_en && wr_hcreset) nst = M_RST;
                    else if (rd_fail || (wr_en && !wr_run)) nst = stop_to_stop ? M_STOP : M_HALT;
            M_STOP: if (wr_en && wr_hcreset) nst = M_RST;
                    else if (xact_done) nst = M_HALT;
            default: begin
                if (exp_cnt == RSTC - 1) nst = M_HALT;
                else exp_cnt++;
            end
        endcase
        if (nst == M_RST && exp_st != M_RST) begin
            exp_abort = 1'b1;
            exp_cnt = 0;
        end
        exp_st = nst;
    endtask

    task automatic compare_all();
        chk("R2", "rd_run", rd_run, exp_st == M_RUN);
        chk("R4", "rd_halted", rd_halted, exp_st == M_HALT);
        chk("R6", "rd_hcreset", rd_hcreset, exp_st == M_RST);
        chk("R6", "pipe_rst", pipe_rst, exp_st == M_RST);
        chk("R6", "port_rst", port_rst, exp_st == M_RST);
        chk("R2", "sched_enable", sched_enable, exp_st == M_RUN);
        chk("R7", "xact_abort", xact_abort, exp_abort);
        chk("R7", "owner_release", owner_release, exp_abort);
        chk("R9", "proto_err", proto_err, exp_perr);
        chk("R3", "run_and_halted", rd_run && rd_halted, 1'b0);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        wr_en = 1'b0; wr_run = 1'b0; wr_hcreset = 1'b0;
        rd_fail = 1'b0; xact_done = 1'b0;
    endtask

    task automatic write(input logic run, input logic hcr);
        wr_en = 1'b1; wr_run = run; wr_hcreset = hcr;
    endtask

    initial begin
        int hi_cnt;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0C7A);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_run", rd_run, 1'b0);
        chk("R1", "rd_halted", rd_halted, 1'b1);
        chk("R1", "rd_hcreset", rd_hcreset, 1'b0);
        chk("R1", "sched_enable", sched_enable, 1'b0);
        chk("R1", "pipe_rst", pipe_rst, 1'b0);
        chk("R1", "port_rst", port_rst, 1'b0);
        chk("R1", "proto_err", proto_err, 1'b0);
        chk("R1", "xact_abort", xact_abort, 1'b0);
        chk("R1", "owner_release", owner_release, 1'b0);

        // R2 start
        write(1'b1, 1'b0); step();
        chk("R2", "run after start", rd_run, 1'b1);

        // R4 graceful stop waits for the busy transaction
        xact_busy = 1'b1;
        write(1'b0, 1'b0); step();
        for (int i = 0; i < 3; i++) begin
            chk("R4", "halted while draining", rd_halted, 1'b0);
            step();
        end
        // R9 run request while stopping is flagged and ignored
        write(1'b1, 1'b0); step();
        chk("R9", "proto_err on run while stopping", proto_err, 1'b1);
        chk("R9", "still stopping run", rd_run, 1'b0);
        chk("R9", "still stopping halted", rd_halted, 1'b0);
        xact_done = 1'b1; step();
        xact_busy = 1'b0;
        chk("R4", "halted after done", rd_halted, 1'b1);

        // R4 stop with done in the same cycle as the request
        write(1'b1, 1'b0); step();
        xact_busy = 1'b1; xact_done = 1'b1;
        write(1'b0, 1'b0); step();
        xact_busy = 1'b0;
        chk("R4", "halted when stop meets done", rd_halted, 1'b1);

        // R5 failed read stops the controller
        write(1'b1, 1'b0); step();
        rd_fail = 1'b1; step();
        chk("R5", "run after failed read", rd_run, 1'b0);
        chk("R5", "halted after failed read", rd_halted, 1'b1);

        // R9 / R6 / R7 / R8 reset while running
        write(1'b1, 1'b0); step();
        write(1'b0, 1'b1); step();
        chk("R9", "proto_err on reset while running", proto_err, 1'b1);
        chk("R7", "abort at reset start", xact_abort, 1'b1);
        hi_cnt = 1;
        write(1'b0, 1'b0); step();           // R8 cancel attempt
        chk("R7", "abort one cycle only", xact_abort, 1'b0);
        if (rd_hcreset) hi_cnt++;
        write(1'b1, 1'b0); step();           // R8 run attempt
        if (rd_hcreset) hi_cnt++;
        while (rd_hcreset && hi_cnt < 100) begin
            step();
            if (rd_hcreset) hi_cnt++;
        end
        checks++;
        if (hi_cnt != RSTC) begin
            errors++;
            $display("FAIL R8 reset length: actual %0d expected %0d", hi_cnt, RSTC);
        end
        chk("R6", "halted after reset", rd_halted, 1'b1);
        chk("R8", "run after reset", rd_run, 1'b0);

        // Random phase with a stub schedule engine
        for (int n = 0; n < 4000; n++) begin
            bit busy_next;
            busy_next = xact_busy;
            if (xact_abort) busy_next = 1'b0;
            else if (xact_busy) begin
                if ($urandom % 4 == 0) xact_done = 1'b1;
            end else if (sched_enable && $urandom % 3 == 0) busy_next = 1'b1;
            xact_busy = busy_next;
            if ($urandom % 6 == 0) write(1'($urandom % 2), ($urandom % 10 == 0));
            if ($urandom % 20 == 0) rd_fail = 1'b1;
            step();
            if (xact_done === 1'b0 && xact_busy && exp_st == M_HALT) xact_busy = 1'b0;
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule